// File: doc/BRIEF.md
# DRAM Spool Buffer Controller

This block turns a byte-wide multiplexed-address DRAM into a large first-in first-out spool between a fast byte producer (the host side) and a slow byte consumer (the printer side). Bytes that the host hands over with a valid/ready strobe go from a single holding register straight onto the DRAM data lines. Bytes that are read back go from the DRAM data lines into a single output register that the printer side drains with its own valid/ready strobe. No processor touches the payload.

The controller keeps a write pointer and a read pointer of `2*MUX_W` bits. Each pointer is split into a row (upper half) and a column (lower half) that share one `MUX_W`-bit address bus. It drives active-low row strobe, column strobe and write-enable lines. A clock-count timer requests a column-before-row refresh, and the refresh is served before any pending data access. When both sides want the memory at once, write and read accesses take turns. With the default `MUX_W = 9`, the store holds 262144 bytes.

Top module: `dram_spool_ctrl`

## Requirements
- R1: Every byte accepted on the input port leaves the output port exactly once, in acceptance order.
- R2: A data access lowers the row strobe while the bus carries the upper pointer half. The column strobe falls at least one clock later, while the bus carries the lower half. Successive writes use pointer values 0, 1, 2, … and successive reads use the same sequence.
- R3: The stored count never exceeds 2^(2*MUX_W). With no draining, exactly 2^(2*MUX_W)+1 bytes are accepted: the full store plus the one output register byte. After that, `full` is 1 and `in_ready` is 0. Pointers wrap to 0 after the last location.
- R4: `empty` is 1 when no byte is held in DRAM. `out_valid` is 0 whenever no byte waits in the output register.
- R5: A refresh lowers the column strobe first, with the row strobe high, and lowers the row strobe on a later clock. Write enable stays high during a refresh.
- R6: Refresh starts are never more than REFRESH_CYCLES+PRECHARGE_CYCLES+8 clocks apart, and this holds under continuous traffic on both ports.
- R7: While both ports keep requesting, consecutive data accesses alternate between write and read.
- R8: After the row strobe rises, both strobes stay high for at least PRECHARGE_CYCLES clocks before either falls again.
- R9: Write enable is low only while the row strobe is low. For a write access it keeps the same level from row strobe fall to column strobe fall. At column strobe fall, the DRAM data output carries the accepted byte for that slot.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R11: After reset all three strobes are high, `in_ready` is 1, `full` is 0, `empty` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | DATA_W | Byte from host |
| in_valid | input | 1 | Host byte present |
| in_ready | output | 1 | Holding register free and store not full |
| out_data | output | DATA_W | Byte to printer |
| out_valid | output | 1 | Output register holds a byte |
| out_ready | input | 1 | Printer takes the byte |
| full | output | 1 | DRAM store holds 2^(2*MUX_W) bytes |
| empty | output | 1 | DRAM store holds no byte |
| dram_addr | output | MUX_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Write data to DRAM |
| dram_dq_in | input | DATA_W | Read data from DRAM |

## Verification
If a pointer or the stored count goes wrong, the effect shows at the ports within one access. The row and column halves seen at the column strobe fall leave the 0, 1, 2, … sequence, and the byte returned to the printer port differs from the scoreboard head. If the count drifts, the accepted total at the full point is off from 2^(2*MUX_W)+1, or `empty` disagrees with the drained scoreboard. A stuck refresh timer or a starved port shows within one refresh period as an oversized gap between refresh starts, or as two data accesses of the same kind in a row.

// File: rtl/dram_spool_pkg.sv
package dram_spool_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_CAS,
    ST_DATA,
    ST_RF_CAS,
    ST_RF_RAS,
    ST_PRE
  } spool_state_t;
endpackage

// File: rtl/dspool_refresh_timer.sv
module dspool_refresh_timer #(
  parameter int PERIOD = 3000
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pend
);
  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0] count;
  logic          tick;

  assign tick = (count == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      pend  <= 1'b0;
    end else begin
      count <= tick ? '0 : count + 1'b1;
      if (tick)     pend <= 1'b1;
      else if (ack) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/dspool_arbiter.sv
module dspool_arbiter (
  input  logic clk,
  input  logic rst,
  input  logic wr_req,
  input  logic rd_req,
  input  logic take,
  output logic gnt_wr,
  output logic gnt_rd
);
  logic last_wr;

  assign gnt_wr = wr_req && (!rd_req || !last_wr);
  assign gnt_rd = rd_req && (!wr_req || last_wr);

  always_ff @(posedge clk) begin
    if (rst)       last_wr <= 1'b0;
    else if (take) last_wr <= gnt_wr;
  end
endmodule

// File: rtl/dram_spool_ctrl.sv
module dram_spool_ctrl
  import dram_spool_pkg::*;
#(
  parameter int MUX_W            = 9,
  parameter int DATA_W           = 8,
  parameter int REFRESH_CYCLES   = 3000,
  parameter int PRECHARGE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              full,
  output logic              empty,
  output logic [MUX_W-1:0]  dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [DATA_W-1:0] dram_dq_out,
  input  logic [DATA_W-1:0] dram_dq_in
);
  localparam int ADDR_W = 2 * MUX_W;
  localparam logic [ADDR_W:0] CAPACITY = {1'b1, {ADDR_W{1'b0}}};
  localparam int PW = $clog2(PRECHARGE_CYCLES) + 1;
  localparam int GAP_MAX = REFRESH_CYCLES + PRECHARGE_CYCLES + 8;
  localparam int SR_W = $clog2(GAP_MAX + 1) + 1;

  spool_state_t      state;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr, acc_addr;
  logic [ADDR_W:0]   cnt;
  logic              hold_vld, out_vld_q, acc_wr;
  logic [DATA_W-1:0] hold_data, out_data_q, dq_q;
  logic [MUX_W-1:0]  addr_q;
  logic              ras_q, cas_q, we_q;
  logic [PW-1:0]     pre_cnt;
  logic              ref_pend, ref_ack, take, gnt_wr, gnt_rd, wr_req, rd_req;

  assign full      = (cnt == CAPACITY);
  assign empty     = (cnt == '0);
  assign in_ready  = !hold_vld && !full;
  assign out_valid = out_vld_q;
  assign out_data  = out_data_q;
  assign dram_addr   = addr_q;
  assign dram_ras_n  = ras_q;
  assign dram_cas_n  = cas_q;
  assign dram_we_n   = we_q;
  assign dram_dq_out = dq_q;

  assign wr_req  = hold_vld && !full;
  assign rd_req  = !empty && !out_vld_q;
  assign ref_ack = (state == ST_IDLE) && ref_pend;
  assign take    = (state == ST_IDLE) && !ref_pend && (gnt_wr || gnt_rd);

  dspool_refresh_timer #(.PERIOD(REFRESH_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .ack(ref_ack), .pend(ref_pend)
  );

  dspool_arbiter u_arb (
    .clk(clk), .rst(rst), .wr_req(wr_req), .rd_req(rd_req), .take(take),
    .gnt_wr(gnt_wr), .gnt_rd(gnt_rd)
  );

  // Input holding register and output register
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vld   <= 1'b0;
      hold_data  <= '0;
      out_vld_q  <= 1'b0;
      out_data_q <= '0;
    end else begin
      if (in_valid && in_ready) begin
        hold_vld  <= 1'b1;
        hold_data <= in_data;
      end else if (state == ST_DATA && acc_wr) begin
        hold_vld <= 1'b0;
      end
      if (state == ST_DATA && !acc_wr) begin
        out_vld_q  <= 1'b1;
        out_data_q <= dram_dq_in;
      end else if (out_vld_q && out_ready) begin
        out_vld_q <= 1'b0;
      end
    end
  end

  // Access sequencer: strobes and address are registered
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      acc_wr   <= 1'b0;
      acc_addr <= '0;
      addr_q   <= '0;
      ras_q    <= 1'b1;
      cas_q    <= 1'b1;
      we_q     <= 1'b1;
      dq_q     <= '0;
      pre_cnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ref_pend) begin
            cas_q <= 1'b0;
            state <= ST_RF_CAS;
          end else if (take) begin
            acc_wr   <= gnt_wr;
            acc_addr <= gnt_wr ? wr_ptr : rd_ptr;
            addr_q   <= gnt_wr ? wr_ptr[ADDR_W-1:MUX_W] : rd_ptr[ADDR_W-1:MUX_W];
            dq_q     <= hold_data;
            state    <= ST_ROW;
          end
        end
        ST_ROW: begin
          ras_q <= 1'b0;
          we_q  <= !acc_wr;
          state <= ST_COL;
        end
        ST_COL: begin
          addr_q <= acc_addr[MUX_W-1:0];
          state  <= ST_CAS;
        end
        ST_CAS: begin
          cas_q <= 1'b0;
          state <= ST_DATA;
        end
        ST_DATA: begin
          ras_q   <= 1'b1;
          cas_q   <= 1'b1;
          we_q    <= 1'b1;
          pre_cnt <= PW'(PRECHARGE_CYCLES - 1);
          if (acc_wr) begin
            wr_ptr <= wr_ptr + 1'b1;
            cnt    <= cnt + 1'b1;
          end else begin
            rd_ptr <= rd_ptr + 1'b1;
            cnt    <= cnt - 1'b1;
          end
          state <= ST_PRE;
        end
        ST_RF_CAS: begin
          ras_q <= 1'b0;
          state <= ST_RF_RAS;
        end
        ST_RF_RAS: begin
          ras_q   <= 1'b1;
          cas_q   <= 1'b1;
          pre_cnt <= PW'(PRECHARGE_CYCLES - 1);
          state   <= ST_PRE;
        end
        ST_PRE: begin
          if (pre_cnt == '0) state <= ST_IDLE;
          else               pre_cnt <= pre_cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Cycles since the last refresh start, watched by p_refresh_gap_r6
  logic [SR_W-1:0] since_ref;
  always_ff @(posedge clk) begin
    if (rst || ref_ack)     since_ref <= '0;
    else if (since_ref != '1) since_ref <= since_ref + 1'b1;
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CAPACITY);
  p_row_then_col_r2: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && !dram_ras_n) |-> $past(!dram_ras_n));
  p_cbr_order_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_ras_n) && !dram_cas_n) |-> ($past(!dram_cas_n) && dram_we_n));
  p_refresh_gap_r6: assert property (@(posedge clk) disable iff (rst)
    since_ref < SR_W'(GAP_MAX));
  p_precharge_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_ras_n) |=> (dram_ras_n && dram_cas_n));
  p_we_in_ras_r9: assert property (@(posedge clk) disable iff (rst)
    !dram_we_n |-> !dram_ras_n);
  p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/dram_spool_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_spool_ctrl_tb_top;
  localparam int MUX_W = 3;
  localparam int CAP   = 1 << (2 * MUX_W);
  localparam int REF   = 64;
  localparam int PRE   = 2;
  localparam int GAP   = REF + PRE + 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, full, empty;
  logic [7:0] out_data, dram_dq_out, dram_dq_in;
  logic [MUX_W-1:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n;

  always #2.5 clk = ~clk;

  dram_spool_ctrl #(.MUX_W(MUX_W), .DATA_W(8), .REFRESH_CYCLES(REF),
                    .PRECHARGE_CYCLES(PRE)) dut_i (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .full(full), .empty(empty), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_in(dram_dq_in)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard
  logic [7:0] sb_q[$];
  logic [7:0] wr_log [0:255];
  int wr_sent = 0;

  // DRAM model and strobe monitor
  logic [7:0] mem [0:CAP-1];
  logic [MUX_W-1:0] row_l = '0;
  logic ras_p = 1'b1, cas_p = 1'b1, acc_we = 1'b1;
  int hi_cnt = 0, cyc = 0, last_ref = 0, ref_cnt = 0;
  int wr_seen = 0, rd_seen = 0, alt_pairs = 0;
  bit alt_win = 0, have_prev = 0, prev_wr = 0;

  initial for (int i = 0; i < CAP; i++) mem[i] = '0;
  assign dram_dq_in = mem[{row_l, dram_addr}];

  always @(posedge clk) begin
    if (rst) begin
      ras_p <= 1'b1; cas_p <= 1'b1; hi_cnt <= 0; cyc <= 0; last_ref <= 0;
    end else begin
      cyc   <= cyc + 1;
      ras_p <= dram_ras_n;
      cas_p <= dram_cas_n;
      if (ras_p && cas_p && !(dram_ras_n && dram_cas_n))
        chk(hi_cnt >= PRE, "R8 precharge clocks", hi_cnt, PRE);
      hi_cnt <= (dram_ras_n && dram_cas_n) ? hi_cnt + 1 : 0;
      if (ras_p && !dram_ras_n) begin
        if (!dram_cas_n) begin
          chk(!cas_p && dram_we_n, "R5 column before row refresh", {cas_p, dram_we_n}, 2'b01);
          chk(cyc - last_ref <= GAP, "R6 refresh gap", cyc - last_ref, GAP);
          last_ref <= cyc;
          ref_cnt  <= ref_cnt + 1;
        end else begin
          row_l  <= dram_addr;
          acc_we <= dram_we_n;
        end
      end
      if (cas_p && !dram_cas_n && !dram_ras_n) begin
        chk(!ras_p, "R2 row strobe leads column strobe", ras_p, 0);
        chk(dram_we_n == acc_we, "R9 write enable steady", dram_we_n, acc_we);
        if (!dram_we_n) begin
          chk({row_l, dram_addr} == (wr_seen % CAP), "R2 R3 write slot",
              {row_l, dram_addr}, wr_seen % CAP);
          chk(dram_dq_out == wr_log[wr_seen % 256], "R9 write data",
              dram_dq_out, wr_log[wr_seen % 256]);
          mem[{row_l, dram_addr}] <= dram_dq_out;
          wr_seen <= wr_seen + 1;
        end else begin
          chk({row_l, dram_addr} == (rd_seen % CAP), "R2 R3 read slot",
              {row_l, dram_addr}, rd_seen % CAP);
          rd_seen <= rd_seen + 1;
        end
        if (alt_win) begin
          if (have_prev) begin
            chk(prev_wr != !dram_we_n, "R7 alternation", !dram_we_n, prev_wr);
            alt_pairs <= alt_pairs + 1;
          end
          have_prev <= 1;
          prev_wr   <= !dram_we_n;
        end
      end
      if (!alt_win) have_prev <= 0;
    end
  end

  // Output monitor, sampled between edges
  bit hold_seen = 0;
  logic [7:0] hold_d = '0;
  always begin
    @(negedge clk);
    #1;
    if (!rst) begin
      if (hold_seen)
        chk(out_valid && out_data == hold_d, "R10 output held",
            {out_valid, out_data}, {1'b1, hold_d});
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0) chk(0, "R1 unexpected byte", out_data, 0);
        else begin
          logic [7:0] e;
          e = sb_q.pop_front();
          chk(out_data == e, "R1 byte order", out_data, e);
        end
      end
      hold_seen = out_valid && !out_ready;
      hold_d    = out_data;
    end
  end

  task automatic send_try(input logic [7:0] b, input int maxw, output bit ok);
    ok = 0;
    @(negedge clk);
    in_data  = b;
    in_valid = 1'b1;
    for (int w = 0; w < maxw; w++) begin
      if (in_ready) begin
        sb_q.push_back(b);
        wr_log[wr_sent % 256] = b;
        wr_sent++;
        ok = 1;
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_drain(input int maxw);
    for (int w = 0; w < maxw && sb_q.size() != 0; w++) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  bit done = 0;
  initial begin
    bit ok;
    int acc;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11, R4: reset state
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R11 strobes high",
        {dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
    chk(in_ready && !full, "R11 ready after reset", {in_ready, full}, 2'b10);
    chk(empty && !out_valid, "R4 empty after reset", {empty, out_valid}, 2'b10);

    // R1: short bursts with gaps, printer draining
    out_ready = 1'b1;
    for (int i = 0; i < 12; i++) begin
      send_try(pat(i), 500, ok);
      if (i % 3 == 2) begin idle_in(); repeat (7) @(negedge clk); end
    end
    idle_in();
    wait_drain(2000);
    chk(sb_q.size() == 0, "R1 burst drained", sb_q.size(), 0);

    // R3: fill with printer stalled
    out_ready = 1'b0;
    acc = 0;
    for (int i = 0; i < CAP + 2; i++) begin
      send_try(pat(100 + i), 100, ok);
      if (ok) acc++;
    end
    idle_in();
    repeat (30) @(negedge clk);
    chk(acc == CAP + 1, "R3 bytes accepted when full", acc, CAP + 1);
    chk(full && !in_ready, "R3 full blocks input", {full, in_ready}, 2'b10);
    chk(!empty && out_valid, "R4 not empty when full", {empty, out_valid}, 2'b01);

    // R4: drain everything
    out_ready = 1'b1;
    wait_drain(3000);
    chk(sb_q.size() == 0, "R1 fill drained", sb_q.size(), 0);
    chk(empty && !out_valid, "R4 empty after drain", {empty, out_valid}, 2'b10);
    chk(!full && in_ready, "R3 ready after drain", {full, in_ready}, 2'b01);

    // R7: preload, then stream on both sides
    out_ready = 1'b0;
    for (int i = 0; i < 4; i++) send_try(pat(300 + i), 200, ok);
    idle_in();
    repeat (30) @(negedge clk);
    alt_win   = 1;
    out_ready = 1'b1;
    for (int i = 0; i < 60; i++) send_try(pat(400 + i), 200, ok);
    alt_win = 0;
    idle_in();
    wait_drain(2000);
    chk(alt_pairs >= 40, "R7 alternation pairs seen", alt_pairs, 40);
    chk(sb_q.size() == 0, "R1 stream drained", sb_q.size(), 0);
    chk(ref_cnt > 0, "R5 refreshes seen", ref_cnt, 1);
    chk(wr_seen == rd_seen, "R2 reads match writes", rd_seen, wr_seen);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", sb_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule